// File: doc/BRIEF.md
# Two-Stage SCL Rate Divider

This block produces the timing strobes that an I2C master's bus engine needs to shape SCL from a fast system clock. An 8-bit clock-control byte sets the rate. Its low field picks a power-of-two prescale, which turns the system clock into a sampling tick. Its upper field picks a linear factor, so that each SCL period takes ten times that factor plus one, counted in sampling ticks.

Each period has an SCL-low half followed by an SCL-high half. On four ticks inside each period the block raises a one-cycle phase strobe: the fall of SCL, the middle of the low half, the rise of SCL, and the middle of the high half. The bus engine uses these to change SDA, drive SCL and sample the bus. Software picks the byte and may rewrite it while the bus is running, for example when the system clock is about to change. A running period always finishes on the value it started with. The new value takes effect at the next period boundary, so no high or low half is ever cut short.

Top module: `scl_clk_div`

## Requirements
- R1: Bits 2:0 of the clock-control byte hold N. While `en` is high, `smp_tick` is a one-cycle pulse that comes once every 2^N clock cycles. The first pulse comes 2^N cycles after `en` rises, counting the first enabled cycle as cycle 1.
- R2: With N = 0 there is no prescale, and `smp_tick` is high on every enabled cycle.
- R3: Bits 6:3 of the byte hold M. An SCL period lasts exactly 10*(M+1) ticks. `scl_high` is low for the first 5*(M+1) ticks of each period and high for the rest.
- R4: Let H = 5*(M+1), Q = floor(H/2) and P = 2*H. A phase strobe fires only together with `smp_tick`, and at most one fires at a time. `phase_stb[0]` fires on tick P of the period (SCL falls after it), `phase_stb[1]` on tick Q, `phase_stb[2]` on tick H (SCL rises after it) and `phase_stb[3]` on tick H+Q. Ticks are numbered from 1 within the period.
- R5: A byte written with `ctl_wr` appears on `ctl_rdata` in the next cycle with bit 7 forced to zero. Bit 7 has no effect on the timing.
- R6: A byte written while `en` is high leaves the current SCL period untouched. The new N and M apply from the first tick after the period ends.
- R7: While `en` is low there are no ticks and no strobes. From the second low cycle on, `scl_high` is low. Any written byte becomes active one cycle after it is written. When `en` rises, timing restarts from the start of a period.
- R8: After reset, `ctl_rdata` reads 0x00 and, with `en` low, `smp_tick`, `phase_stb` and `scl_high` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low holds the divider at the start of a period |
| ctl_wr | input | 1 | Write strobe for the clock-control byte |
| ctl_wdata | input | 8 | Clock-control byte to write (bits 6:3 factor M, bits 2:0 prescale N) |
| ctl_rdata | output | 8 | Written clock-control byte, bit 7 reads zero |
| smp_tick | output | 1 | Sampling tick strobe |
| phase_stb | output | 4 | Quarter-point strobes: 0 fall, 1 mid-low, 2 rise, 3 mid-high |
| scl_high | output | 1 | Ideal SCL level for the current half period |

## Verification
The hardest case to reach from the ports is a rewrite that lands in the middle of a running period. The old prescale and factor must keep running to the exact period boundary, and the new pair must then start with a fresh prescale count. To get there, the stimulus enables the divider on one setting, writes a second setting halfway through the first period, and checks every cycle against an arithmetic model that switches settings at the computed boundary. This is done both from slow to fast and from fast to slow. Near-exhaustive sweeps over every N and every M also check the tick spacing, the half-period split and the strobe positions cycle by cycle.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;

    localparam int CTL_W    = 8;
    localparam int N_W      = 3;
    localparam int M_W      = 4;
    localparam int BASE_DIV = 10;
    localparam int NUM_PH   = 4;

    localparam int PRE_W   = (1 << N_W) - 1;
    localparam int PER_MAX = BASE_DIV * (1 << M_W);
    localparam int CNT_W   = $clog2(PER_MAX + 1);

    typedef struct packed {
        logic [M_W-1:0] mult;
        logic [N_W-1:0] pow;
    } clk_cfg_t;

    typedef enum logic [1:0] {
        PH_FALL    = 2'd0,
        PH_MIDLOW  = 2'd1,
        PH_RISE    = 2'd2,
        PH_MIDHIGH = 2'd3
    } phase_e;

    function automatic clk_cfg_t cfg_from_byte(input logic [CTL_W-1:0] b);
        return clk_cfg_t'(b[N_W+M_W-1:0]);
    endfunction

    function automatic logic [CTL_W-1:0] cfg_to_byte(input clk_cfg_t c);
        return {{(CTL_W-N_W-M_W){1'b0}}, c};
    endfunction

    function automatic logic [PRE_W-1:0] pre_limit(input logic [N_W-1:0] p);
        return PRE_W'((1 << p) - 1);
    endfunction

    function automatic logic [CNT_W-1:0] half_len(input logic [M_W-1:0] m);
        return CNT_W'((BASE_DIV / 2) * (int'(m) + 1));
    endfunction

endpackage

// File: rtl/scl_cfg_reg.sv
module scl_cfg_reg
    import scl_div_pkg::*;
#(
    parameter logic [CTL_W-1:0] RST_CTL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             wr,
    input  logic [CTL_W-1:0] wdata,
    input  logic             apply,
    output logic [CTL_W-1:0] rdata,
    output clk_cfg_t         active
);

    clk_cfg_t pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= cfg_from_byte(RST_CTL);
            active  <= cfg_from_byte(RST_CTL);
        end else begin
            if (wr) begin
                pending <= cfg_from_byte(wdata);
            end
            if (!en || apply) begin
                active <= pending;
            end
        end
    end

    assign rdata = cfg_to_byte(pending);

    AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (en && !apply) |=> $stable(active)); // R6

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler
    import scl_div_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           en,
    input  logic [N_W-1:0] pow,
    output logic           tick
);

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] lim;

    assign lim  = pre_limit(pow);
    assign tick = en && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_PRE_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= lim); // R1

endmodule

// File: rtl/scl_phase_gen.sv
module scl_phase_gen
    import scl_div_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tick,
    input  logic [M_W-1:0]    mult,
    output logic [NUM_PH-1:0] phase_stb,
    output logic              scl_high,
    output logic              period_end
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half;
    logic [CNT_W-1:0] qtr;
    logic [CNT_W-1:0] last;
    logic [CNT_W-1:0] pts [NUM_PH];

    assign half = half_len(mult);
    assign qtr  = half >> 1;
    assign last = (half << 1) - 1'b1;

    always_comb begin
        pts[PH_FALL]    = last;
        pts[PH_MIDLOW]  = qtr - 1'b1;
        pts[PH_RISE]    = half - 1'b1;
        pts[PH_MIDHIGH] = half + qtr - 1'b1;
    end

    for (genvar g = 0; g < NUM_PH; g++) begin : g_stb
        assign phase_stb[g] = tick && (cnt == pts[g]);
    end

    assign period_end = phase_stb[PH_FALL];
    assign scl_high   = (cnt >= half);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= (cnt == last) ? '0 : cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= last); // R3
    AST_PH_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_stb)); // R4
    AST_PH_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (phase_stb != '0) |-> tick); // R4
    AST_SCL_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_high) |-> $past(phase_stb[PH_RISE])); // R4
    AST_SCL_FALL: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_high) && $past(en)) |-> $past(phase_stb[PH_FALL])); // R3

endmodule

// File: rtl/scl_clk_div.sv
module scl_clk_div
    import scl_div_pkg::*;
#(
    parameter logic [7:0] RST_CTL = 8'h00
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       ctl_wr,
    input  logic [7:0] ctl_wdata,
    output logic [7:0] ctl_rdata,
    output logic       smp_tick,
    output logic [3:0] phase_stb,
    output logic       scl_high
);

    clk_cfg_t active;
    logic     period_end;

    scl_cfg_reg #(.RST_CTL(RST_CTL)) u_cfg (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .wr     (ctl_wr),
        .wdata  (ctl_wdata),
        .apply  (period_end),
        .rdata  (ctl_rdata),
        .active (active)
    );

    scl_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .pow  (active.pow),
        .tick (smp_tick)
    );

    scl_phase_gen u_ph (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .tick       (smp_tick),
        .mult       (active.mult),
        .phase_stb  (phase_stb),
        .scl_high   (scl_high),
        .period_end (period_end)
    );

    AST_IDLE_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !en |-> (!smp_tick && phase_stb == '0)); // R7
    AST_IDLE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
        ($past(!en) && !en) |-> !scl_high); // R7
    AST_WR_READBACK: assert property (@(posedge clk) disable iff (rst)
        ctl_wr |=> (ctl_rdata == {1'b0, $past(ctl_wdata[6:0])})); // R5

endmodule

// File: tb/tb_scl_clk_div.sv
module tb_scl_clk_div;

    logic       clk = 1'b0;
    logic       rst;
    logic       en;
    logic       ctl_wr;
    logic [7:0] ctl_wdata;
    logic [7:0] ctl_rdata;
    logic       smp_tick;
    logic [3:0] phase_stb;
    logic       scl_high;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    scl_clk_div dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ctl_wr    (ctl_wr),
        .ctl_wdata (ctl_wdata),
        .ctl_rdata (ctl_rdata),
        .smp_tick  (smp_tick),
        .phase_stb (phase_stb),
        .scl_high  (scl_high)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Arithmetic model of cycle k after enable (k = 0 is the first enabled cycle)
    task automatic chk_cycle(input int n, input int m, input int k, input string ctx);
        int div = 1 << n;
        int per = 10 * (m + 1);
        int h   = per / 2;
        int q   = h / 2;
        int c   = (k / div) % per;
        bit t   = ((k % div) == div - 1);
        logic [3:0] stb = '0;
        bit ok;
        if (t) begin
            stb[0] = (c == per - 1);
            stb[1] = (c == q - 1);
            stb[2] = (c == h - 1);
            stb[3] = (c == h + q - 1);
        end
        ok = (smp_tick == t) && (phase_stb == stb) && (scl_high == (c >= h));
        total++;
        if (!ok) begin
            bad++;
            if (smp_tick != t)
                $display("FAIL %s %s tick k=%0d actual=%0b expected=%0b",
                         (n == 0) ? "R2" : "R1", ctx, k, smp_tick, t);
            if (phase_stb != stb)
                $display("FAIL R4 %s stb k=%0d actual=%0b expected=%0b",
                         ctx, k, phase_stb, stb);
            if (scl_high != (c >= h))
                $display("FAIL R3 %s scl k=%0d actual=%0b expected=%0b",
                         ctx, k, scl_high, (c >= h));
        end
    endtask

    // Write with en low; byte becomes active one cycle later (R7)
    task automatic load_cfg(input logic [7:0] val);
        @(negedge clk);
        en = 1'b0;
        ctl_wr = 1'b1;
        ctl_wdata = val;
        @(negedge clk);
        ctl_wr = 1'b0;
        chk("R5 readback", ctl_rdata, {1'b0, val[6:0]});
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic run_cfg(input int n, input int m, input int len, input string ctx);
        load_cfg(8'((m << 3) | n));
        en = 1'b1;
        for (int k = 0; k < len; k++) begin
            #1;
            chk_cycle(n, m, k, ctx);
            @(negedge clk);
        end
        en = 1'b0;
    endtask

    task automatic run_switch(input int na, input int ma, input int nb, input int mb);
        int la = (1 << na) * 10 * (ma + 1);
        int lb = (1 << nb) * 10 * (mb + 1);
        load_cfg(8'((ma << 3) | na));
        en = 1'b1;
        for (int k = 0; k < la + 2 * lb; k++) begin
            #1;
            if (k < la) chk_cycle(na, ma, k, "R6 old");
            else        chk_cycle(nb, mb, k - la, "R6 new");
            if (k == la / 2 + 1) begin
                chk("R5 runtime readback", ctl_rdata, (mb << 3) | nb);
                ctl_wr = 1'b0;
            end
            if (k == la / 2) begin
                ctl_wr = 1'b1;
                ctl_wdata = 8'((mb << 3) | nb);
            end
            @(negedge clk);
        end
        en = 1'b0;
    endtask

    initial begin
        #1500000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        en = 1'b0;
        ctl_wr = 1'b0;
        ctl_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk("R8 rdata", ctl_rdata, 0);
        chk("R8 tick", smp_tick, 0);
        chk("R8 stb", phase_stb, 0);
        chk("R8 scl", scl_high, 0);

        // R5: bit 7 reads zero and is ignored by the timing
        load_cfg(8'hFF);
        chk("R5 bit7", ctl_rdata, 8'h7F);
        en = 1'b1;
        for (int k = 0; k < 128 * 160 + 40; k++) begin
            #1;
            chk_cycle(7, 15, k, "R5 bit7 set");
            @(negedge clk);
        end
        en = 1'b0;

        // R1/R2: every prescale with the smallest factor
        for (int n = 0; n < 8; n++) run_cfg(n, 0, (1 << n) * 20, "R1 sweep");
        // R3/R4: every factor with prescale 0 and 1
        for (int m = 0; m < 16; m++) run_cfg(0, m, 20 * (m + 1), "R3 sweep");
        for (int m = 0; m < 16; m++) run_cfg(1, m, 20 * (m + 1) + 3, "R4 sweep");
        run_cfg(3, 5, 8 * 120, "R4 mixed");

        // R6: rewrite mid-period, slow to fast and fast to slow
        run_switch(2, 3, 0, 1);
        run_switch(0, 1, 2, 0);
        run_switch(1, 2, 3, 4);

        // R7: drop enable mid-period, then restart with a new setting
        load_cfg(8'h08);
        en = 1'b1;
        for (int k = 0; k < 33; k++) begin
            #1;
            chk_cycle(0, 1, k, "R7 pre");
            @(negedge clk);
        end
        en = 1'b0;
        #1;
        chk("R7 tick off", smp_tick, 0);
        chk("R7 stb off", phase_stb, 0);
        @(negedge clk);
        for (int k = 0; k < 5; k++) begin
            #1;
            chk("R7 idle tick", smp_tick, 0);
            chk("R7 idle stb", phase_stb, 0);
            chk("R7 idle scl", scl_high, 0);
            @(negedge clk);
        end
        run_cfg(2, 1, 4 * 40, "R7 restart");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule